// File: doc/BRIEF.md
# Two-Wire Tuner Control Register Bank

This block is a target-only two-wire serial (I2C, standard mode) slave that owns sixteen byte-wide control registers for a tuner front end. A host selects a register with a sub-address byte sent after the device address. It then either writes one or more data bytes, or issues a repeated start and reads one or more bytes back. The pointer steps forward after every data byte and wraps from the last register to the first.

Register contents leave the block as plain output bits for the analog sections. Read-only bit positions are filled from a status input bus when read, and ignore writes. Two registers together form a 15-bit synthesizer divide word. That word is handed to its consumer only once both halves have been rewritten, so the consumer never sees a half-updated value. A self-clearing bit restores every register to its power-up value and aborts the transfer that set it. A sleep input takes the whole serial interface off the bus.

SCL and SDA are sampled with a system clock at least eight times faster than SCL. Both lines are resynchronised and debounced before any bus event is decoded.

Top module: `tuner_i2c_regfile`

## Requirements
- R1: Only the 7-bit device address 0x60 is acknowledged: address byte 0xC0 selects a write and 0xC1 selects a read (R/W in bit 0). Any other address byte gets no acknowledge, and the block ignores the bus until the next start.
- R2: After the address byte 0xC0, the next byte (its low 4 bits) selects a register and each following data byte is stored there. The stored byte appears at `regs_o[8*n +: 8]` for register n. Register contents change only through such writes or through a reset.
- R3: In a multi-byte write or read, the register pointer advances by one after each data byte, and it wraps from register 15 to register 0.
- R4: A read consists of a write phase carrying the sub-address, a repeated start, and then 0xC1. Data is shifted out MSB first for as long as the host acknowledges. A host NACK ends the transfer, and a stop condition always releases SDA.
- R5: Read-only positions are bit 7 of registers 0, 3, 4, 7 and 8, bits 7:6 of registers 11 and 14, bits 7:5 of register 13, and bits 3:0 of register 15. Written values at these positions are dropped, so they read 0 on `regs_o`. A bus read returns `stat_i` at those positions.
- R6: `div_o` equals {register 0 bits 6:0, register 1 bits 7:0}. It is reloaded only after both registers have been written since the last reload, in either order.
- R7: After reset, the registers hold these values: 0x00 in registers 0–2, 0x40, 0x6E, 0x3C, 0x08, 0x38, 0x20, 0xA2, 0xF1, 0x38, 0xD0, 0x10, 0x30 in registers 3–14, and 0x80 in register 15. `div_o` is 0 after reset.
- R8: A data byte written to register 15 with bit 6 set is not acknowledged. It returns every register and `div_o` to the R7 values, and bit 6 reads back 0.
- R9: While `sleep_i` is high, the block never drives SDA and ignores all bus traffic.
- R10: An SDA pulse shorter than FILT_LEN system clocks while SCL is high is neither a start nor a stop, and does not corrupt the bit being transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Takes the serial interface off the bus while high |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pulls SDA low when high (open drain) |
| stat_i | input | 128 | Live values for the read-only bit positions, 8 bits per register |
| regs_o | output | 128 | Register contents, register n in bits 8n+7:8n |
| div_o | output | 15 | Coherent synthesizer divide word |

## Verification
The hardest states to reach are the wrap of the pointer in the middle of a burst and a divider half that is pending when a new half arrives. Directed bursts therefore start at register 14 and cross into registers 0 and 1. Single writes to the two divider registers are sent in both orders, and one half is rewritten twice before its partner arrives. A one-clock SDA pulse is inserted in the high phase of a data bit during a live write, which would look like a start or stop if it were not filtered. The abort case writes the self-clearing bit in a normal transfer and checks both the missing acknowledge and the restored bank.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } bus_state_t;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_SUB,
    PH_DATA
  } rx_phase_t;

  localparam int DIV_HI_REG = 0;
  localparam int DIV_LO_REG = 1;
  localparam int DIV_W      = 15;

  // power-up contents of each register
  function automatic logic [7:0] reset_value(input int unsigned idx);
    case (idx)
      3:       return 8'h40;
      4:       return 8'h6E;
      5:       return 8'h3C;
      6:       return 8'h08;
      7:       return 8'h38;
      8:       return 8'h20;
      9:       return 8'hA2;
      10:      return 8'hF1;
      11:      return 8'h38;
      12:      return 8'hD0;
      13:      return 8'h10;
      14:      return 8'h30;
      15:      return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  // bit positions that are sourced from status inputs, not storage
  function automatic logic [7:0] ro_bits(input int unsigned idx);
    case (idx)
      0, 3, 4, 7, 8: return 8'h80;
      11, 14:        return 8'hC0;
      13:            return 8'hE0;
      15:            return 8'h0F;
      default:       return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt,
  output logic sda_lvl
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0] sync_q1, sync_q2, prev_q;
  logic [1:0] filt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q1 <= 2'b11;
      sync_q2 <= 2'b11;
      prev_q  <= 2'b11;
    end else begin
      sync_q1 <= {scl_i, sda_i};
      sync_q2 <= sync_q1;
      prev_q  <= filt;
    end
  end

  // index 1 = SCL, index 0 = SDA; a level is accepted after FILT_LEN equal samples
  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [CW-1:0] run_q;
    logic          lvl_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        run_q <= '0;
        lvl_q <= 1'b1;
      end else if (sync_q2[g] == lvl_q) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        lvl_q <= sync_q2[g];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
    assign filt[g] = lvl_q;
  end

  assign scl_rise  = filt[1] & ~prev_q[1];
  assign scl_fall  = ~filt[1] & prev_q[1];
  assign start_evt = filt[1] & prev_q[1] & prev_q[0] & ~filt[0];
  assign stop_evt  = filt[1] & prev_q[1] & ~prev_q[0] & filt[0];
  assign sda_lvl   = filt[0];

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import tuner_i2c_pkg::*;
#(
  parameter int         AW       = 4,
  parameter logic [6:0] DEV_ADDR = 7'h60,
  parameter int         CLR_REG  = 15,
  parameter int         CLR_BIT  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep_i,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          sda_lvl,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          clr_o,
  output logic          sda_oe_o
);
  bus_state_t    state;
  rx_phase_t     phase;
  logic [AW-1:0] ptr;
  logic [7:0]    shreg;
  logic [2:0]    cnt;
  logic          got8, rd_mode, nack;

  assign rd_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phase    <= PH_DEV;
      ptr      <= '0;
      shreg    <= '0;
      cnt      <= '0;
      got8     <= 1'b0;
      rd_mode  <= 1'b0;
      nack     <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      clr_o    <= 1'b0;
      sda_oe_o <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      clr_o <= 1'b0;
      if (sleep_i || stop_evt) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_evt) begin
        state    <= ST_RX;
        phase    <= PH_DEV;
        cnt      <= '0;
        got8     <= 1'b0;
        rd_mode  <= 1'b0;
        sda_oe_o <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_lvl};
              cnt   <= cnt + 1'b1;
              if (cnt == 3'd7) got8 <= 1'b1;
            end else if (scl_fall && got8) begin
              got8 <= 1'b0;
              case (phase)
                PH_DEV: begin
                  if (shreg[7:1] == DEV_ADDR) begin
                    rd_mode  <= shreg[0];
                    sda_oe_o <= 1'b1;
                    state    <= ST_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                PH_SUB: begin
                  ptr      <= shreg[AW-1:0];
                  phase    <= PH_DATA;
                  sda_oe_o <= 1'b1;
                  state    <= ST_ACK;
                end
                default: begin
                  if (ptr == AW'(CLR_REG) && shreg[CLR_BIT]) begin
                    clr_o <= 1'b1;
                    state <= ST_IDLE;
                  end else begin
                    wr_en    <= 1'b1;
                    wr_addr  <= ptr;
                    wr_data  <= shreg;
                    ptr      <= ptr + 1'b1;
                    sda_oe_o <= 1'b1;
                    state    <= ST_ACK;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_oe_o <= 1'b0;
              if (rd_mode) begin
                shreg    <= rd_data;
                sda_oe_o <= ~rd_data[7];
                ptr      <= ptr + 1'b1;
                cnt      <= '0;
                state    <= ST_TX;
              end else begin
                if (phase == PH_DEV) phase <= PH_SUB;
                cnt   <= '0;
                state <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                sda_oe_o <= 1'b0;
                state    <= ST_RACK;
              end else begin
                shreg    <= {shreg[6:0], 1'b0};
                sda_oe_o <= ~shreg[6];
                cnt      <= cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              nack <= sda_lvl;
            end else if (scl_fall) begin
              if (nack) begin
                state <= ST_IDLE;
              end else begin
                shreg    <= rd_data;
                sda_oe_o <= ~rd_data[7];
                ptr      <= ptr + 1'b1;
                cnt      <= '0;
                state    <= ST_TX;
              end
            end
          end
          default: sda_oe_o <= 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_reg_store.sv
module cfg_reg_store
  import tuner_i2c_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [AW-1:0]     rd_addr,
  input  logic [NREG*8-1:0] stat_i,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] regs_o,
  output logic [DIV_W-1:0]  div_o
);
  logic [7:0] mem [NREG];
  logic       hi_seen, lo_seen;
  logic [7:0] rd_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= reset_value(i);
      hi_seen <= 1'b0;
      lo_seen <= 1'b0;
      div_o   <= '0;
    end else begin
      if (hi_seen && lo_seen) begin
        div_o   <= {mem[DIV_HI_REG][DIV_W-9:0], mem[DIV_LO_REG]};
        hi_seen <= 1'b0;
        lo_seen <= 1'b0;
      end
      if (wr_en) begin
        mem[wr_addr] <= wr_data & ~ro_bits(int'(wr_addr));
        if (wr_addr == AW'(DIV_HI_REG)) hi_seen <= 1'b1;
        if (wr_addr == AW'(DIV_LO_REG)) lo_seen <= 1'b1;
      end
    end
  end

  assign rd_mask = ro_bits(int'(rd_addr));
  assign rd_data = (mem[rd_addr] & ~rd_mask) | (stat_i[rd_addr*8 +: 8] & rd_mask);

  for (genvar i = 0; i < NREG; i++) begin : g_out
    assign regs_o[i*8 +: 8] = mem[i];
  end

endmodule

// File: rtl/tuner_i2c_regfile.sv
module tuner_i2c_regfile
  import tuner_i2c_pkg::*;
#(
  parameter int         NREG     = 16,
  parameter int         FILT_LEN = 4,
  parameter logic [6:0] DEV_ADDR = 7'h60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [NREG*8-1:0] stat_i,
  output logic [NREG*8-1:0] regs_o,
  output logic [DIV_W-1:0]  div_o
);
  localparam int AW = $clog2(NREG);

  logic          scl_rise, scl_fall, start_evt, stop_evt, sda_lvl;
  logic          wr_en, clr_q, core_rst;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;

  // soft clear feeds the same synchronous reset as the external one
  assign core_rst = rst | clr_q;

  i2c_line_filter #(.FILT_LEN(FILT_LEN)) filt_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_lvl(sda_lvl)
  );

  i2c_target_fsm #(.AW(AW), .DEV_ADDR(DEV_ADDR)) fsm_i (
    .clk(clk), .rst(core_rst), .sleep_i(sleep_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_lvl(sda_lvl),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clr_o(clr_q), .sda_oe_o(sda_oe_o)
  );

  cfg_reg_store #(.NREG(NREG), .AW(AW)) store_i (
    .clk(clk), .rst(core_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .stat_i(stat_i), .rd_data(rd_data),
    .regs_o(regs_o), .div_o(div_o)
  );

endmodule

// File: rtl/tuner_i2c_regfile_chk.sv
module tuner_i2c_regfile_chk
  import tuner_i2c_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sleep_i,
  input logic              sda_oe_o,
  input logic              stop_evt,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic              clr,
  input logic [NREG*8-1:0] regs_o,
  input logic [DIV_W-1:0]  div_o
);
  logic [NREG*8-1:0] dflt_flat;
  for (genvar i = 0; i < NREG; i++) begin : g_dflt
    assign dflt_flat[i*8 +: 8] = reset_value(i);
  end

  // R9: sleeping interface never pulls SDA
  assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> !sda_oe_o);

  // R4: a stop condition releases the line
  assert_stop_releases_R4: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_oe_o);

  // R2: storage holds unless a write or soft clear happens
  assert_regs_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !clr) |=> $stable(regs_o));

  // R8: soft clear restores the power-up bank
  assert_clr_defaults_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (regs_o == dflt_flat));

  // R6: divide word moves only after a divider-register write or a clear
  assert_div_moves_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_o) |-> (($past(wr_en, 2) && ($past(wr_addr, 2) < AW'(2))) || $past(clr)));

endmodule

bind tuner_i2c_regfile tuner_i2c_regfile_chk #(.NREG(NREG), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .sleep_i(sleep_i), .sda_oe_o(sda_oe_o),
  .stop_evt(stop_evt), .wr_en(wr_en), .wr_addr(wr_addr), .clr(clr_q),
  .regs_o(regs_o), .div_o(div_o)
);

// File: tb/tuner_i2c_regfile_tb.sv
module tuner_i2c_regfile_tb_top;
  localparam int NREG = 16;
  localparam int QT   = 12;
  localparam int HT   = 24;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, sleep = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  logic glitch = 1'b0, glitch_arm = 1'b0;
  logic sda_oe;
  logic [NREG*8-1:0] stat = '0;
  logic [NREG*8-1:0] regs;
  logic [14:0] div;
  wire sda_line = m_sda & ~sda_oe & ~glitch;

  tuner_i2c_regfile dut_i (
    .clk(clk), .rst(rst), .sleep_i(sleep), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .stat_i(stat), .regs_o(regs), .div_o(div)
  );

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_r [NREG];
  logic [7:0] wbuf [NREG];
  logic [7:0] rbuf [NREG];
  logic hi_p, lo_p;
  logic [14:0] exp_div;

  function automatic logic [7:0] dflt(input int a);
    case (a)
      3: return 8'h40;  4: return 8'h6E;  5: return 8'h3C;  6: return 8'h08;
      7: return 8'h38;  8: return 8'h20;  9: return 8'hA2; 10: return 8'hF1;
      11: return 8'h38; 12: return 8'hD0; 13: return 8'h10; 14: return 8'h30;
      15: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rom(input int a);
    if (a == 0 || a == 3 || a == 4 || a == 7 || a == 8) return 8'h80;
    if (a == 11 || a == 14) return 8'hC0;
    if (a == 13) return 8'hE0;
    if (a == 15) return 8'h0F;
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_read(input int a);
    return (exp_r[a] & ~rom(a)) | (stat[a*8 +: 8] & rom(a));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) exp_r[i] = dflt(i);
    hi_p = 1'b0; lo_p = 1'b0; exp_div = '0;
  endtask

  task automatic model_write(input int a, input logic [7:0] d);
    exp_r[a] = d & ~rom(a);
    if (a == 0) hi_p = 1'b1;
    if (a == 1) lo_p = 1'b1;
    if (hi_p && lo_p) begin
      exp_div = {exp_r[0][6:0], exp_r[1]};
      hi_p = 1'b0; lo_p = 1'b0;
    end
  endtask

  task automatic check_bank(input string tag);
    for (int i = 0; i < NREG; i++) chk(tag, regs[i*8 +: 8], exp_r[i]);
    chk({tag, " div"}, div, exp_div);
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hold(QT); m_scl = 1'b1; hold(HT);
    m_sda = 1'b0; hold(HT); m_scl = 1'b0; hold(QT);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hold(QT); m_scl = 1'b1; hold(HT); m_sda = 1'b1; hold(HT);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; hold(QT); m_scl = 1'b1;
    if (glitch_arm && b) begin
      hold(HT / 2); glitch = 1'b1; hold(1); glitch = 1'b0; hold(HT - HT / 2 - 1);
    end else begin
      hold(HT);
    end
    m_scl = 1'b0; hold(QT);
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; hold(QT); m_scl = 1'b1; hold(HT - 2);
    b = sda_line; hold(2); m_scl = 1'b0; hold(QT);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic nak);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(nak);
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(last);
  endtask

  // naks = {device byte, sub-address byte, last data byte}
  task automatic bus_write(input logic [7:0] dev, input int sub, input int n, output logic [2:0] naks);
    logic k;
    bus_start();
    send_byte(dev, naks[2]);
    send_byte(8'(sub), naks[1]);
    naks[0] = 1'b0;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], k);
      naks[0] = k;
    end
    bus_stop();
    hold(4);
  endtask

  task automatic bus_read(input int sub, input int n, output logic [2:0] naks);
    logic k;
    bus_start();
    send_byte(8'hC0, naks[2]);
    send_byte(8'(sub), k);
    bus_start();
    send_byte(8'hC1, naks[1]);
    naks[0] = k;
    for (int i = 0; i < n; i++) recv_byte(i == n - 1, rbuf[i]);
    bus_stop();
    hold(4);
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [2:0] nk;
    void'($urandom(32'd2024));
    model_reset();
    hold(10); rst = 1'b0; hold(10);

    // R7: power-up contents
    check_bank("R7 reset bank");
    chk("R7 sda released", sda_oe, 1'b0);
    bus_read(3, 1, nk);
    chk("R7/R4 read reg3 acks", nk, 3'b000);
    chk("R7/R4 read reg3", rbuf[0], exp_read(3));

    // R2: single write
    wbuf[0] = 8'h5A;
    bus_write(8'hC0, 5, 1, nk);
    model_write(5, 8'h5A);
    chk("R2 write acks", nk, 3'b000);
    check_bank("R2 single write");

    // R3: burst that wraps 14,15,0,1 (also completes divider pair, R6)
    wbuf[0] = 8'h0C; wbuf[1] = 8'h91; wbuf[2] = 8'h2B; wbuf[3] = 8'hC4;
    bus_write(8'hC0, 14, 4, nk);
    for (int i = 0; i < 4; i++) model_write((14 + i) % 16, wbuf[i]);
    chk("R3 burst acks", nk, 3'b000);
    check_bank("R3 wrap write");
    bus_read(14, 4, nk);
    for (int i = 0; i < 4; i++) chk("R3/R4 wrap read", rbuf[i], exp_read((14 + i) % 16));

    // R6: halves in either order, repeated half
    wbuf[0] = 8'h77; bus_write(8'hC0, 1, 1, nk); model_write(1, 8'h77);
    chk("R6 lone low half", div, exp_div);
    wbuf[0] = 8'h13; bus_write(8'hC0, 0, 1, nk); model_write(0, 8'h13);
    chk("R6 pair low-then-high", div, exp_div);
    wbuf[0] = 8'h05; bus_write(8'hC0, 0, 1, nk); model_write(0, 8'h05);
    wbuf[0] = 8'h66; bus_write(8'hC0, 0, 1, nk); model_write(0, 8'h66);
    chk("R6 high half twice", div, exp_div);
    wbuf[0] = 8'hE8; bus_write(8'hC0, 1, 1, nk); model_write(1, 8'hE8);
    chk("R6 pair high-then-low", div, exp_div);

    // R5: read-only positions
    stat = {$urandom, $urandom, $urandom, $urandom};
    wbuf[0] = 8'hFF; bus_write(8'hC0, 11, 1, nk); model_write(11, 8'hFF);
    chk("R5 ro bits dropped", regs[11*8 +: 8], 8'h3F);
    bus_read(11, 1, nk);
    chk("R5 ro bits from status", rbuf[0], exp_read(11));
    bus_read(0, 1, nk);
    chk("R5 reg0 live flag", rbuf[0], exp_read(0));

    // R1: foreign address ignored
    wbuf[0] = 8'h00;
    bus_write(8'hA0, 5, 1, nk);
    chk("R1 foreign address nak", nk[2], 1'b1);
    check_bank("R1 bank untouched");

    // R10: glitch during a live write
    glitch_arm = 1'b1;
    wbuf[0] = 8'hB7; bus_write(8'hC0, 12, 1, nk); model_write(12, 8'hB7);
    glitch_arm = 1'b0;
    chk("R10 glitched write acks", nk, 3'b000);
    chk("R10 glitched value", regs[12*8 +: 8], exp_r[12]);

    // R9: sleep
    sleep = 1'b1; hold(4);
    wbuf[0] = 8'h99; bus_write(8'hC0, 5, 1, nk);
    chk("R9 no ack in sleep", nk[2], 1'b1);
    check_bank("R9 bank untouched");
    sleep = 1'b0; hold(4);

    // randomized writes and sequential read-back
    for (int it = 0; it < 12; it++) begin
      int a, n;
      a = int'($urandom % 16);
      n = 1 + int'($urandom % 3);
      for (int i = 0; i < n; i++) begin
        wbuf[i] = 8'($urandom);
        if ((a + i) % 16 == 15) wbuf[i][6] = 1'b0;
      end
      bus_write(8'hC0, a, n, nk);
      for (int i = 0; i < n; i++) model_write((a + i) % 16, wbuf[i]);
      chk("R2/R3 random write acks", nk, 3'b000);
      bus_read(a, n, nk);
      chk("R1/R4 random read acks", nk, 3'b000);
      for (int i = 0; i < n; i++) chk("R3/R4 random read", rbuf[i], exp_read((a + i) % 16));
    end
    check_bank("R2 random bank");

    // R8: soft clear
    wbuf[0] = 8'hC0;
    bus_write(8'hC0, 15, 1, nk);
    chk("R8 clear byte not acked", nk, 3'b001);
    model_reset();
    check_bank("R8 restored bank");
    bus_read(15, 1, nk);
    chk("R8 clear bit reads 0", rbuf[0], exp_read(15));

    finish_up();
  end

endmodule